// File: doc/BRIEF.md
# Single- and Dual-Slope PWM Timer

This block is a 16-bit timer with one waveform output. A single counter runs in one of two shapes. In the sawtooth (single-slope) shape it climbs from zero to a ceiling and then restarts at zero. In the triangle (dual-slope) shape it climbs to the ceiling and then descends back to zero. The ceiling can be a fixed 8-, 9- or 10-bit maximum, the programmable period register, or the compare register itself. A clock divider gates every counter step. The compare value is double buffered, so software can change the duty cycle at any moment without a glitch on the output.

Software sets up the block through a small write-only register port. The port holds the mode code, the output behaviour, the divider setting, the period and the compare value. The block drives one registered PWM output. It also gives a single-clock cycle-boundary pulse that a controller can use to pace its duty-cycle updates.

Top module: `pwm_timer`

## Requirements
- R1: The register port writes when `wr_en` is high. The addresses are 0 for the mode code [3:0], 1 for the output behaviour [1:0], 2 for the divider select [2:0], 3 for the period and 4 for the compare value. Writing the mode clears the counter, the count direction and the output. After reset all registers are zero, and `pwm_out` and `evt_flag` are low.
- R2: The divider select sets the clocks per counter step: 1 gives 1, 2 gives 8, 3 gives 64, 4 gives 256 and 5 gives 1024.
- R3: Sawtooth mode codes are 5, 6 and 7 (ceiling 0x00FF, 0x01FF, 0x03FF), 14 (ceiling = period register) and 15 (ceiling = compare value). One cycle lasts ceiling+1 steps.
- R4: In sawtooth mode, behaviour 2 gives a high time of ceiling−compare steps per cycle (0 when compare ≥ ceiling), and behaviour 3 gives the complement. A compare of 0 therefore gives a one-step low spike each cycle.
- R5: Triangle mode codes are 1, 2 and 3 (ceiling 0x00FF, 0x01FF, 0x03FF), 10 (ceiling = period register) and 11 (ceiling = compare value). The count goes up to the ceiling and back down, holding the ceiling value for one step. One cycle lasts 2×ceiling steps.
- R6: In triangle mode, behaviour 2 clears the output on an upward match and sets it on a downward match. This gives a high time of 2×min(compare, ceiling) steps; behaviour 3 gives the complement.
- R7: In mode 15 with behaviour 1, the output toggles at every match, which gives a square wave with a period of 2×(compare+1) steps. A compare of 0 toggles the output every step.
- R8: A written compare value takes effect at the zero restart in sawtooth mode and at the ceiling in triangle mode. While the divider is stopped it takes effect at once.
- R9: `evt_flag` pulses for one clock each time the count returns to zero.
- R10: Divider select 0, 6 or 7 stops the counter. The output then holds its level and no boundary pulse occurs.
- R11: Behaviour 0, behaviour 1 outside mode 15, and any mode code not listed above drive the output low.
- R12: In triangle mode, a programmable ceiling below 3 is raised to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 1 | Registered waveform output |
| evt_flag | output | 1 | One-clock pulse when the count returns to zero |

## Verification
The bench sweeps the compare value from 0 to past the ceiling, in both shapes and both polarities, and counts the period and the high time between boundary pulses. An off-by-one in the restart, or a wrong priority between set and clear at the ceiling, shows up as a high time that is one step off, or as a missing constant level at compare 0 and at the ceiling. A compare write made partway through a cycle must leave the current sawtooth cycle unchanged and must change only the second half of a triangle cycle; loading it early or late distorts those counts. The bench also checks the divider ratios, the toggle square wave down to every-step toggling, the clamped triangle ceiling, and that a stopped divider freezes the output and suppresses the boundary pulses.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [2:0] {
    TS_NONE, TS_FIX8, TS_FIX9, TS_FIX10, TS_PERIOD, TS_CMPA
  } top_src_e;

  typedef struct packed {
    logic     valid;
    logic     dual;
    top_src_e src;
  } mode_dec_t;

  localparam int unsigned PC_MIN_TOP = 3;
  localparam int unsigned MAX_SHIFT  = 10;

  function automatic mode_dec_t decode_mode(input logic [3:0] m);
    mode_dec_t d;
    d.valid = 1'b1;
    d.dual  = 1'b0;
    d.src   = TS_NONE;
    case (m)
      4'd1:  begin d.dual = 1'b1; d.src = TS_FIX8;   end
      4'd2:  begin d.dual = 1'b1; d.src = TS_FIX9;   end
      4'd3:  begin d.dual = 1'b1; d.src = TS_FIX10;  end
      4'd10: begin d.dual = 1'b1; d.src = TS_PERIOD; end
      4'd11: begin d.dual = 1'b1; d.src = TS_CMPA;   end
      4'd5:  d.src = TS_FIX8;
      4'd6:  d.src = TS_FIX9;
      4'd7:  d.src = TS_FIX10;
      4'd14: d.src = TS_PERIOD;
      4'd15: d.src = TS_CMPA;
      default: d.valid = 1'b0;
    endcase
    return d;
  endfunction

  function automatic int unsigned presc_shift(input logic [2:0] s);
    case (s)
      3'd1:    return 0;
      3'd2:    return 3;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 10;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_timer_pkg::*;
#(
  parameter int unsigned DIV_W = MAX_SHIFT
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  output logic       tick,
  output logic       running
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  always_comb begin
    running = (sel >= 3'd1) && (sel <= 3'd5);
    mask    = DIV_W'((1 << presc_shift(sel)) - 1);
    tick    = running && ((div_q & mask) == mask);
  end

  // Divided settings never step on two adjacent clocks while the select is steady.
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && sel >= 3'd2 && sel <= 3'd5) |=> (!tick || !$stable(sel)));

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             running,
  input  logic             clear,
  input  logic [3:0]       mode,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic             upd,
  output logic             dual,
  output logic             toggle_ok,
  output logic [CNT_W-1:0] cnt_d,
  output logic             down_d,
  output logic [CNT_W-1:0] cmp_d,
  output logic [CNT_W-1:0] top_d,
  output logic             evt_q
);
  localparam logic [CNT_W-1:0] TOP8  = CNT_W'(255);
  localparam logic [CNT_W-1:0] TOP9  = CNT_W'(511);
  localparam logic [CNT_W-1:0] TOP10 = CNT_W'(1023);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(PC_MIN_TOP);

  mode_dec_t        dec;
  logic [CNT_W-1:0] cnt_q, cmp_q, top_now;
  logic             down_q, evt_d;

  function automatic logic [CNT_W-1:0] top_of(input mode_dec_t d,
                                               input logic [CNT_W-1:0] prd,
                                               input logic [CNT_W-1:0] c);
    logic [CNT_W-1:0] t;
    case (d.src)
      TS_FIX8:   t = TOP8;
      TS_FIX9:   t = TOP9;
      TS_FIX10:  t = TOP10;
      TS_PERIOD: t = prd;
      TS_CMPA:   t = c;
      default:   t = '0;
    endcase
    if (d.dual && t < FLOOR) t = FLOOR;
    return t;
  endfunction

  always_comb begin
    dec       = decode_mode(mode);
    dual      = dec.dual;
    toggle_ok = dec.valid && !dec.dual && (dec.src == TS_CMPA);
    upd       = tick && dec.valid;
    top_now   = top_of(dec, period, cmp_q);
    cnt_d     = cnt_q;
    down_d    = down_q;
    cmp_d     = running ? cmp_q : cmp_buf;
    if (upd) begin
      if (!dec.dual) begin
        down_d = 1'b0;
        if (cnt_q >= top_now) begin
          cnt_d = '0;
          cmp_d = cmp_buf;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (!down_q) begin
        if (cnt_q >= top_now - 1'b1) begin
          cnt_d  = top_now;
          down_d = 1'b1;
          cmp_d  = cmp_buf;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q <= CNT_W'(1)) begin
          cnt_d  = '0;
          down_d = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
    top_d = top_of(dec, period, cmp_d);
    evt_d = upd && (cnt_d == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      evt_q  <= 1'b0;
      cmp_q  <= rst ? '0 : cmp_buf;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      evt_q  <= evt_d;
      cmp_q  <= cmp_d;
    end
  end

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clear) |=> $stable(cnt_q));

  assert_evt_at_bottom_R9: assert property (@(posedge clk) disable iff (rst)
    evt_q |-> (cnt_q == '0));

  assert_reverse_floor_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(down_q) |-> (cnt_q >= FLOOR));

  assert_evt_single_R9: assert property (@(posedge clk) disable iff (rst)
    (evt_q && dec.dual) |=> !evt_q);

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             upd,
  input  logic [1:0]       com,
  input  logic             dual,
  input  logic             toggle_ok,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic             down_d,
  input  logic [CNT_W-1:0] cmp_d,
  input  logic [CNT_W-1:0] top_d,
  output logic             pwm_q
);
  logic active, out_d;

  always_comb begin
    if (dual) active = down_d ? (cnt_d <= cmp_d) : (cnt_d < cmp_d);
    else      active = (cmp_d <= cnt_d) && (cnt_d < top_d);
    case (com)
      2'd1:    out_d = (toggle_ok && cnt_d == cmp_d) ? !pwm_q : (toggle_ok && pwm_q);
      2'd2:    out_d = active;
      2'd3:    out_d = !active;
      default: out_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clear) pwm_q <= 1'b0;
    else if (upd)     pwm_q <= out_d;
  end

  assert_com_off_low_R11: assert property (@(posedge clk) disable iff (rst)
    (upd && com == 2'd0) |=> !pwm_q);

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              pwm_out,
  output logic              evt_flag
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_COM  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_PRD  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(4);

  logic [3:0]       mode_q;
  logic [1:0]       com_q;
  logic [2:0]       sel_q;
  logic [CNT_W-1:0] period_q, cmp_buf_q;
  logic             mode_clr;

  assign mode_clr = wr_en && (wr_addr == A_MODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      com_q     <= '0;
      sel_q     <= '0;
      period_q  <= '0;
      cmp_buf_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MODE: mode_q    <= wr_data[3:0];
        A_COM:  com_q     <= wr_data[1:0];
        A_SEL:  sel_q     <= wr_data[2:0];
        A_PRD:  period_q  <= wr_data;
        A_CMP:  cmp_buf_q <= wr_data;
        default: ;
      endcase
    end
  end

  logic             tick, running, upd, dual, toggle_ok, down_d, evt_q, pwm_q;
  logic [CNT_W-1:0] cnt_d, cmp_d, top_d;

  pwm_prescaler u_presc (
    .clk(clk), .rst(rst), .sel(sel_q), .tick(tick), .running(running)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .running(running), .clear(mode_clr),
    .mode(mode_q), .period(period_q), .cmp_buf(cmp_buf_q),
    .upd(upd), .dual(dual), .toggle_ok(toggle_ok), .cnt_d(cnt_d),
    .down_d(down_d), .cmp_d(cmp_d), .top_d(top_d), .evt_q(evt_q)
  );

  pwm_wave #(.CNT_W(CNT_W)) u_wave (
    .clk(clk), .rst(rst), .clear(mode_clr), .upd(upd), .com(com_q),
    .dual(dual), .toggle_ok(toggle_ok), .cnt_d(cnt_d), .down_d(down_d),
    .cmp_d(cmp_d), .top_d(top_d), .pwm_q(pwm_q)
  );

  assign pwm_out  = pwm_q;
  assign evt_flag = evt_q;

  assert_stopped_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!running && !mode_clr) |=> ($stable(pwm_out) && !evt_flag));

endmodule

// File: tb/pwm_timer_bench.sv
module pwm_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_out, evt_flag;
  int          n_vec = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  pwm_timer u_pwm_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .evt_flag(evt_flag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input int mode, input int com, input int prd,
                     input int cmp, input int sel);
    wr(2, 0); wr(0, mode); wr(1, com); wr(3, prd); wr(4, cmp); wr(2, sel);
  endtask

  // Window from one boundary pulse to the clock before the next one.
  task automatic measure(output int len, output int hi,
                         input int wr_at, input int wr_val);
    do @(negedge clk); while (!evt_flag);
    len = 0; hi = 0;
    do begin
      wr_en = 1'b0;
      hi += int'(pwm_out);
      len++;
      if (len == wr_at) begin
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'(wr_val);
      end
      @(negedge clk);
    end while (!evt_flag);
    wr_en = 1'b0;
  endtask

  task automatic steady(output int len, output int hi);
    int l0, h0;
    measure(l0, h0, 0, 0);
    measure(len, hi, 0, 0);
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL R9 watchdog: actual hung expected finished run");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int len, hi, exp_hi, prev, tr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pwm_out == 1'b0, "R1", "pwm_out after reset", int'(pwm_out), 0);
    chk(evt_flag == 1'b0, "R1", "evt_flag after reset", int'(evt_flag), 0);

    // R3 R4 R5 R6 R9: sweep compare over both shapes and polarities, period 7
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 10; c++) begin
        for (int p = 0; p < 2; p++) begin
          cfg(m == 0 ? 14 : 10, 2 + p, 7, c, 1);
          steady(len, hi);
          if (m == 0) begin
            exp_hi = (c <= 7) ? 7 - c : 0;
            if (p == 1) exp_hi = 8 - exp_hi;
            chk(len == 8, "R3", "sawtooth period", len, 8);
            chk(hi == exp_hi, "R4", "sawtooth high time", hi, exp_hi);
          end else begin
            exp_hi = 2 * imin(c, 7);
            if (p == 1) exp_hi = 14 - exp_hi;
            chk(len == 14, "R5", "triangle period", len, 14);
            chk(hi == exp_hi, "R6", "triangle high time", hi, exp_hi);
          end
        end
      end
    end

    // R3 fixed sawtooth ceilings
    for (int k = 0; k < 3; k++) begin
      cfg(5 + k, 2, 0, 64, 1);
      steady(len, hi);
      chk(len == (256 << k), "R3", "fixed sawtooth period", len, 256 << k);
      chk(hi == (256 << k) - 65, "R4", "fixed sawtooth high", hi, (256 << k) - 65);
    end
    // R5 fixed triangle ceilings
    for (int k = 0; k < 3; k++) begin
      cfg(1 + k, 2, 0, 64, 1);
      steady(len, hi);
      chk(len == 2 * ((256 << k) - 1), "R5", "fixed triangle period", len, 2 * ((256 << k) - 1));
      chk(hi == 128, "R6", "fixed triangle high", hi, 128);
    end

    // R12 clamped ceiling: mode 11 with compare 1
    cfg(11, 2, 0, 1, 1);
    steady(len, hi);
    chk(len == 6, "R12", "clamped triangle period", len, 6);
    chk(hi == 2, "R12", "clamped triangle high", hi, 2);

    // R2 divider ratios
    for (int s = 2; s <= 5; s++) begin
      int n;
      n = (s == 2) ? 8 : (s == 3) ? 64 : (s == 4) ? 256 : 1024;
      cfg(14, 2, 7, 3, s);
      steady(len, hi);
      chk(len == 8 * n, "R2", "divided period", len, 8 * n);
      chk(hi == 4 * n, "R2", "divided high time", hi, 4 * n);
    end

    // R8 double buffer, sawtooth: write mid-cycle
    cfg(14, 2, 7, 2, 1);
    steady(len, hi);
    measure(len, hi, 3, 6);
    chk(hi == 5, "R8", "sawtooth cycle of the write", hi, 5);
    measure(len, hi, 0, 0);
    chk(hi == 1, "R8", "sawtooth cycle after the write", hi, 1);
    // R8 double buffer, triangle: second half takes the new value
    cfg(10, 2, 7, 2, 1);
    steady(len, hi);
    measure(len, hi, 3, 6);
    chk(hi == 8, "R8", "triangle cycle of the write", hi, 8);
    measure(len, hi, 0, 0);
    chk(hi == 12, "R8", "triangle cycle after the write", hi, 12);

    // R7 toggle square waves
    for (int k = 0; k < 2; k++) begin
      int cv;
      cv = (k == 0) ? 0 : 3;
      cfg(15, 1, 0, cv, 1);
      steady(len, hi);
      chk(len == cv + 1, "R7", "toggle wrap period", len, cv + 1);
      tr = 0;
      prev = int'(pwm_out);
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        if (int'(pwm_out) != prev) tr++;
        prev = int'(pwm_out);
      end
      chk(tr == 16 / (cv + 1), "R7", "toggle transitions in 16 clocks", tr, 16 / (cv + 1));
    end

    // R10 stop holds output, no pulses; R1 register port restart
    cfg(14, 2, 7, 3, 1);
    steady(len, hi);
    repeat (5) @(negedge clk);
    wr(2, 0);
    prev = int'(pwm_out);
    tr = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (int'(pwm_out) != prev || evt_flag) tr++;
    end
    chk(tr == 0, "R10", "changes while stopped", tr, 0);
    wr(2, 1);
    steady(len, hi);
    chk(len == 8, "R10", "period after restart", len, 8);

    // R11 behaviour 0, toggle outside mode 15, unknown mode
    cfg(14, 0, 7, 3, 1);
    steady(len, hi);
    chk(hi == 0, "R11", "behaviour 0 high time", hi, 0);
    cfg(10, 1, 7, 3, 1);
    steady(len, hi);
    chk(hi == 0, "R11", "toggle in triangle high time", hi, 0);
    cfg(0, 2, 7, 3, 1);
    tr = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pwm_out || evt_flag) tr++;
    end
    chk(tr == 0, "R11", "activity under unknown mode", tr, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule